// File: doc/BRIEF.md
# Bidirectional Transceiver Register

This block sits between two data ports, called A and B, and carries a word in each direction. Each direction has one storage stage. The stage has three behaviours:

- **Transparent:** it passes its input straight through while its latch-enable is high.
- **Held:** it keeps its value while latch-enable is low and its clock stays at one level.
- **Captured:** it takes new data on a rising edge of its own clock while latch-enable is low.

Each direction also has an active-low output-enable. The block shows it as an active-high drive-enable beside the data vector, so a pad ring or an on-chip bus can turn it into a tri-state driver.

The word is split into independent slices, two 9-bit halves by default. Each slice has its own six controls: output-enable, latch-enable and clock for A-to-B, and the same three for B-to-A. The slices can be used separately as narrow transceivers or together as one wide one.

A test-mode input stops normal operation. It turns off every drive-enable and makes every storage stage ignore its clock and latch-enable. An asynchronous active-low reset clears every stage to zero.

Top module: `ubt_xcvr`

## Requirements
- R1: With the A-to-B latch-enable of slice h high and test mode off, that slice of `b_o` equals the same slice of `a_i` with no clock edge needed. Slice h occupies bits [h*HALF_W +: HALF_W].
- R2: With latch-enable low and no rising clock edge, the stage output stays unchanged while its input changes. When latch-enable falls, the stage keeps the input value present at that moment.
- R3: With latch-enable low and test mode off, a rising edge of the direction clock loads the current input into the stage, and the output shows it after that edge.
- R4: The drive-enable for a slice and direction is 1 exactly when that slice's active-low output-enable is 0 and test mode is off.
- R5: B-to-A behaves as R1 to R4 describe, using `b_i`, `a_o`, `a_drv_o` and the `*_ba_*` controls.
- R6: Controls and data of one slice do not change the outputs of any other slice.
- R7: While `test_i` is 1, all drive-enables are 0, and clock edges and latch-enable changes leave every stored value unchanged.
- R8: Turning the output-enable off and on again does not alter the stored value, so the data output shows the same word afterwards.
- R9: `rst_ni` low clears every storage stage to zero at once, without a clock. The outputs read zero after reset while latch-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_i | input | 1 | Test mode: disables drive and freezes storage |
| a_i | input | HALF_W*N_HALF | Data arriving on port A |
| b_i | input | HALF_W*N_HALF | Data arriving on port B |
| oe_ab_ni | input | N_HALF | A-to-B output-enable per slice, active low |
| le_ab_i | input | N_HALF | A-to-B latch-enable per slice |
| clk_ab_i | input | N_HALF | A-to-B clock per slice |
| oe_ba_ni | input | N_HALF | B-to-A output-enable per slice, active low |
| le_ba_i | input | N_HALF | B-to-A latch-enable per slice |
| clk_ba_i | input | N_HALF | B-to-A clock per slice |
| b_o | output | HALF_W*N_HALF | Data driven toward port B |
| b_drv_o | output | N_HALF | Drive-enable for `b_o`, per slice |
| a_o | output | HALF_W*N_HALF | Data driven toward port A |
| a_drv_o | output | N_HALF | Drive-enable for `a_o`, per slice |

## Verification
Each slice and direction is swept through all 512 slice values in transparent mode. This separates a stage that follows its input from one that is stuck, loses bits or mixes slices.

A stepped series of values is then clocked in, and each one is followed by its complement on the input with no edge. This tells capture on the edge apart from transparency and from a missed load.

Separate phases switch the output-enable, enter test mode while pulsing clocks and raising latch-enables, and pulse reset. These check that stored words survive a disable, stay frozen in test mode and clear without a clock.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   // Control set of one direction of one slice
   typedef struct packed {
      logic oe_n;  // output-enable, active low
      logic le;    // latch-enable: high = transparent
      logic clk;   // capture clock, rising edge
   } ubt_ctl_t;

endpackage

// File: rtl/ubt_stage.sv
module ubt_stage
   import ubt_pkg::*;
#(
   parameter int unsigned W = 9
) (
   input  logic           rst_ni,
   input  logic           test_i,
   input  ubt_ctl_t       ctl_i,
   input  logic [W-1:0]   d_i,
   output logic [W-1:0]   q_o,
   output logic           drive_o
);

   logic          clk;
   logic          le_eff;
   logic          fresh_clr;
   logic          fresh_q;   // 1: edge register holds the newest value
   logic [W-1:0]  lat_q;
   logic [W-1:0]  flp_q;

   assign clk       = ctl_i.clk;
   assign le_eff    = ctl_i.le & ~test_i;
   assign fresh_clr = le_eff | ~rst_ni;

   // Level-sensitive half: follows input while transparent
   always_latch begin
      if (!rst_ni)     lat_q = '0;
      else if (le_eff) lat_q = d_i;
   end

   // Edge half: loads on rising clock while latch-enable is low
   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                     flp_q <= '0;
      else if (!ctl_i.le && !test_i)   flp_q <= d_i;
   end

   // Selects which half carries the most recent value
   always_ff @(posedge clk or posedge fresh_clr) begin
      if (fresh_clr)    fresh_q <= 1'b0;
      else if (!test_i) fresh_q <= 1'b1;
   end

   assign q_o     = le_eff ? d_i : (fresh_q ? flp_q : lat_q);
   assign drive_o = ~ctl_i.oe_n & ~test_i;

endmodule

// File: rtl/ubt_half.sv
module ubt_half
   import ubt_pkg::*;
#(
   parameter int unsigned HALF_W = 9
) (
   input  logic              rst_ni,
   input  logic              test_i,
   input  ubt_ctl_t          ctl_ab_i,
   input  ubt_ctl_t          ctl_ba_i,
   input  logic [HALF_W-1:0] a_i,
   input  logic [HALF_W-1:0] b_i,
   output logic [HALF_W-1:0] b_o,
   output logic              b_drv_o,
   output logic [HALF_W-1:0] a_o,
   output logic              a_drv_o
);

   ubt_stage #(.W(HALF_W)) u_ab (
      .rst_ni  (rst_ni),
      .test_i  (test_i),
      .ctl_i   (ctl_ab_i),
      .d_i     (a_i),
      .q_o     (b_o),
      .drive_o (b_drv_o)
   );

   ubt_stage #(.W(HALF_W)) u_ba (
      .rst_ni  (rst_ni),
      .test_i  (test_i),
      .ctl_i   (ctl_ba_i),
      .d_i     (b_i),
      .q_o     (a_o),
      .drive_o (a_drv_o)
   );

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
   import ubt_pkg::*;
#(
   parameter int unsigned HALF_W = 9,
   parameter int unsigned N_HALF = 2,
   localparam int unsigned W     = HALF_W * N_HALF
) (
   input  logic              rst_ni,
   input  logic              test_i,
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic [N_HALF-1:0] oe_ab_ni,
   input  logic [N_HALF-1:0] le_ab_i,
   input  logic [N_HALF-1:0] clk_ab_i,
   input  logic [N_HALF-1:0] oe_ba_ni,
   input  logic [N_HALF-1:0] le_ba_i,
   input  logic [N_HALF-1:0] clk_ba_i,
   output logic [W-1:0]      b_o,
   output logic [N_HALF-1:0] b_drv_o,
   output logic [W-1:0]      a_o,
   output logic [N_HALF-1:0] a_drv_o
);

   if (HALF_W < 1 || N_HALF < 1) begin : g_bad_cfg
      $error("ubt_xcvr: HALF_W and N_HALF must both be at least 1");
   end

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      ubt_ctl_t ctl_ab;
      ubt_ctl_t ctl_ba;

      assign ctl_ab = '{oe_n: oe_ab_ni[h], le: le_ab_i[h], clk: clk_ab_i[h]};
      assign ctl_ba = '{oe_n: oe_ba_ni[h], le: le_ba_i[h], clk: clk_ba_i[h]};

      ubt_half #(.HALF_W(HALF_W)) u_half (
         .rst_ni   (rst_ni),
         .test_i   (test_i),
         .ctl_ab_i (ctl_ab),
         .ctl_ba_i (ctl_ba),
         .a_i      (a_i[h*HALF_W +: HALF_W]),
         .b_i      (b_i[h*HALF_W +: HALF_W]),
         .b_o      (b_o[h*HALF_W +: HALF_W]),
         .b_drv_o  (b_drv_o[h]),
         .a_o      (a_o[h*HALF_W +: HALF_W]),
         .a_drv_o  (a_drv_o[h])
      );
   end

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
   parameter int unsigned HALF_W = 9,
   parameter int unsigned N_HALF = 2,
   localparam int unsigned W     = HALF_W * N_HALF
) (
   input logic              rst_ni,
   input logic              test_i,
   input logic [W-1:0]      a_i,
   input logic [W-1:0]      b_i,
   input logic [N_HALF-1:0] le_ab_i,
   input logic [N_HALF-1:0] clk_ab_i,
   input logic [N_HALF-1:0] le_ba_i,
   input logic [N_HALF-1:0] clk_ba_i,
   input logic [W-1:0]      b_o,
   input logic [N_HALF-1:0] b_drv_o,
   input logic [W-1:0]      a_o,
   input logic [N_HALF-1:0] a_drv_o
);

   AST_TEST_NO_DRIVE: assert property (@(posedge clk_ab_i[0]) disable iff (!rst_ni)
      test_i |-> (a_drv_o == '0 && b_drv_o == '0)); // R7

   for (genvar h = 0; h < N_HALF; h++) begin : g_chk
      AST_AB_TRANSPARENT: assert property (@(negedge clk_ab_i[h]) disable iff (!rst_ni)
         (le_ab_i[h] && !test_i) |-> b_o[h*HALF_W +: HALF_W] == a_i[h*HALF_W +: HALF_W]); // R1

      AST_AB_CAPTURE: assert property (@(posedge clk_ab_i[h]) disable iff (!rst_ni)
         (!le_ab_i[h] && !test_i) |=>
         (le_ab_i[h] || test_i || b_o[h*HALF_W +: HALF_W] == $past(a_i[h*HALF_W +: HALF_W]))); // R3

      AST_BA_TRANSPARENT: assert property (@(negedge clk_ba_i[h]) disable iff (!rst_ni)
         (le_ba_i[h] && !test_i) |-> a_o[h*HALF_W +: HALF_W] == b_i[h*HALF_W +: HALF_W]); // R5

      AST_BA_CAPTURE: assert property (@(posedge clk_ba_i[h]) disable iff (!rst_ni)
         (!le_ba_i[h] && !test_i) |=>
         (le_ba_i[h] || test_i || a_o[h*HALF_W +: HALF_W] == $past(b_i[h*HALF_W +: HALF_W]))); // R5
   end

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HALF_W(HALF_W), .N_HALF(N_HALF)) u_chk (
   .rst_ni   (rst_ni),
   .test_i   (test_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .le_ab_i  (le_ab_i),
   .clk_ab_i (clk_ab_i),
   .le_ba_i  (le_ba_i),
   .clk_ba_i (clk_ba_i),
   .b_o      (b_o),
   .b_drv_o  (b_drv_o),
   .a_o      (a_o),
   .a_drv_o  (a_drv_o)
);

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HW = 9;
   localparam int NH = 2;
   localparam int W  = HW * NH;

   logic          rst_n;
   logic          test;
   logic [W-1:0]  a, b;
   logic [NH-1:0] oe_ab_n, le_ab, clk_ab, oe_ba_n, le_ba, clk_ba;
   logic [W-1:0]  b_o, a_o;
   logic [NH-1:0] b_drv, a_drv;

   int nchk = 0;
   int nerr = 0;

   ubt_xcvr #(.HALF_W(HW), .N_HALF(NH)) u_ubt_xcvr (
      .rst_ni   (rst_n),
      .test_i   (test),
      .a_i      (a),
      .b_i      (b),
      .oe_ab_ni (oe_ab_n),
      .le_ab_i  (le_ab),
      .clk_ab_i (clk_ab),
      .oe_ba_ni (oe_ba_n),
      .le_ba_i  (le_ba),
      .clk_ba_i (clk_ba),
      .b_o      (b_o),
      .b_drv_o  (b_drv),
      .a_o      (a_o),
      .a_drv_o  (a_drv)
   );

   // d = 0: A-to-B, d = 1: B-to-A
   task automatic put(int d, int h, logic [HW-1:0] v);
      if (d == 0) a[h*HW +: HW] = v;
      else        b[h*HW +: HW] = v;
   endtask

   function automatic logic [HW-1:0] got(int d, int h);
      return (d == 0) ? b_o[h*HW +: HW] : a_o[h*HW +: HW];
   endfunction

   function automatic logic drv(int d, int h);
      return (d == 0) ? b_drv[h] : a_drv[h];
   endfunction

   task automatic set_le(int d, int h, logic v);
      if (d == 0) le_ab[h] = v;
      else        le_ba[h] = v;
   endtask

   task automatic set_oe_n(int d, int h, logic v);
      if (d == 0) oe_ab_n[h] = v;
      else        oe_ba_n[h] = v;
   endtask

   task automatic pulse(int d, int h);
      if (d == 0) clk_ab[h] = 1'b1;
      else        clk_ba[h] = 1'b1;
      #(CLK_PERIOD / 2);
      if (d == 0) clk_ab[h] = 1'b0;
      else        clk_ba[h] = 1'b0;
      #(CLK_PERIOD / 2);
   endtask

   task automatic check(string req, string what, logic [HW-1:0] act, logic [HW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin : main
      logic [HW-1:0] keep [2][NH];
      logic [HW-1:0] oth;
      logic [HW-1:0] v;

      rst_n = 1'b0; test = 1'b0; a = '0; b = '0;
      oe_ab_n = '0; oe_ba_n = '0; le_ab = '0; le_ba = '0; clk_ab = '0; clk_ba = '0;
      #CLK_PERIOD;
      rst_n = 1'b1;
      #1;

      // Reset state
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++) begin
            check("R9", "reset value", got(d, h), '0);
            check("R4", "drive after reset", {8'b0, drv(d, h)}, 9'd1);
         end

      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++) begin
            string tg;
            tg  = (d == 0) ? "R1" : "R5";
            oth = got(d, 1 - h);

            // R1 / R5: transparent sweep over every slice value
            set_le(d, h, 1'b1);
            for (int k = 0; k < (1 << HW); k++) begin
               put(d, h, k[HW-1:0]);
               #1;
               check(tg, "transparent", got(d, h), k[HW-1:0]);
            end

            // R2: latch-enable falling keeps last value, input changes ignored
            put(d, h, 9'h0A5);
            #1;
            set_le(d, h, 1'b0);
            #1;
            put(d, h, 9'h15A);
            #1;
            check("R2", "hold after le fall", got(d, h), 9'h0A5);

            // R3: capture on rising edge, then hold against complement input
            for (int k = 0; k < 32; k++) begin
               v = 9'((k * 37 + 5) % 512);
               put(d, h, v);
               #1;
               pulse(d, h);
               put(d, h, ~v);
               #1;
               check((d == 0) ? "R3" : "R5", "clocked capture", got(d, h), v);
            end

            // R4 / R8: disable then re-enable keeps stored word
            set_oe_n(d, h, 1'b1);
            #1;
            check("R4", "drive off", {8'b0, drv(d, h)}, 9'd0);
            check("R8", "value while disabled", got(d, h), 9'((31 * 37 + 5) % 512));
            set_oe_n(d, h, 1'b0);
            #1;
            check("R4", "drive on", {8'b0, drv(d, h)}, 9'd1);
            check("R8", "value after re-enable", got(d, h), 9'((31 * 37 + 5) % 512));

            // R6: other slice untouched
            check("R6", "other slice unchanged", got(d, 1 - h), oth);
         end

      // R7: test mode freezes storage and removes drive
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++) begin
            keep[d][h] = 9'(9'h100 + d * 16 + h * 3);
            put(d, h, keep[d][h]);
            #1;
            pulse(d, h);
         end
      test = 1'b1;
      #1;
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++) begin
            check("R7", "drive in test", {8'b0, drv(d, h)}, 9'd0);
            put(d, h, ~keep[d][h]);
            #1;
            pulse(d, h);
            set_le(d, h, 1'b1);
            #1;
            check("R7", "frozen in test", got(d, h), keep[d][h]);
            set_le(d, h, 1'b0);
         end
      #1;
      test = 1'b0;
      #1;
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++) begin
            check("R7", "value after test", got(d, h), keep[d][h]);
            check("R4", "drive after test", {8'b0, drv(d, h)}, 9'd1);
         end

      // R9: asynchronous clear without clock
      rst_n = 1'b0;
      #1;
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++)
            check("R9", "async clear", got(d, h), '0);
      rst_n = 1'b1;
      #1;
      for (int d = 0; d < 2; d++)
         for (int h = 0; h < NH; h++)
            check("R9", "after reset release", got(d, h), '0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule